// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Writer

This block is the receive engine of a single DMA channel. A byte stream arrives on a valid/ready/last interface, and the block stores each byte into memory buffers described by a linked chain of four-word data descriptors. A descriptor closes in one of two cases: its buffer is full, or the stream marks the end of a packet. When a descriptor closes, the block writes back the address one past the last byte it actually wrote. It also flags a packet end in the stored descriptor and pulses event bits. It then either follows the chain to the next descriptor or, at end of list, marks the channel context as disabled and stops.

All memory traffic uses one word-wide port with byte enables. Reads return data one cycle after the request. A pulse on the start input begins a run, taking the address of the first descriptor and the address of the channel context. Software decoding, interrupt masking and acknowledgement are handled elsewhere and consume the event pulses.

Top module: `rxdesc_writer`

## Requirements
- R1: After reset the block is idle: stream ready low, running low, channel end-of-list flag low, no memory request, no event bits.
- R2: A start pulse while idle fetches the descriptor at the given word-aligned pointer with four word reads at offsets 0 (next pointer), 4 (buffer start), 8 (flags) and 12 (buffer end, exclusive), and stream ready stays low during the fetch.
- R3: Each accepted byte is written at the current buffer pointer as one memory write to the aligned word with a single byte enable on lane pointer[1:0] and the byte replicated on all lanes, so neighbouring bytes are untouched; the pointer then increments.
- R4: When the pointer reaches the buffer end, the descriptor closes: the flags word is written back and the end word (offset 12) is overwritten with the pointer.
- R5: An accepted byte with last set closes the descriptor early; the end word then records the address after that byte, bit 14 of the stored flags word is set, and event bit 3 pulses once.
- R6: On every close whose descriptor has flags bit 4 set, event bits 0 and 1 pulse together once; otherwise they stay low.
- R7: On a close whose flags bit 0 is clear, the next descriptor is fetched from the next pointer and filling restarts at its buffer start.
- R8: On a close whose flags bit 0 is set, the context word at context pointer + 4 is read and written back with bit 15 set and its other bits kept, then the channel end-of-list flag rises, running falls, and stream ready stays low until the next start.
- R9: Stream ready is high only while running and filling a descriptor, never during fetch, write-back or idle.
- R10: A descriptor whose buffer start equals its end closes without accepting any byte, its end word equals its start and bit 14 stays clear.
- R11: A start pulse while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (ignored while running) |
| desc_ptr_i | input | ADDR_W | Byte address of the first data descriptor |
| ctx_ptr_i | input | ADDR_W | Byte address of the channel context |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Byte ends a packet |
| s_ready_o | output | 1 | Block accepts a byte this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| evt_o | output | 4 | Raw event pulses: bits 0 and 1 done, bit 3 packet end |
| running_o | output | 1 | A run is in progress |
| chan_eol_o | output | 1 | Channel reached end of list |

## Verification
The assertions check these properties on every cycle:
- Ready appears only while running and never once the channel has reached end of list.
- Every accepted byte produces exactly one single-lane write.
- The two done event bits always move together.
- Reads are word aligned.
- The block issues no memory request while idle.
- End of list coincides with the stop.

Only the bench's scenarios can show the following, by checking the memory image after each run:
- The written-back end addresses and packet-end flags.
- The chaining order.
- Byte placement with neighbours preserved.
- The context disable bit.
- The number of done and packet-end events per chain, including empty buffers and ignored start pulses.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned WORD_BYTES = WORD_W / 8;
   localparam int unsigned LANE_W     = $clog2(WORD_BYTES);

   // word index of each descriptor field
   localparam int unsigned DW_NEXT  = 0;
   localparam int unsigned DW_BUF   = 1;
   localparam int unsigned DW_FLAGS = 2;
   localparam int unsigned DW_END   = 3;

   // flag bit positions in the descriptor flags word
   localparam int unsigned FL_EOL   = 0;
   localparam int unsigned FL_IRQ   = 4;
   localparam int unsigned FL_INEOP = 14;

   // context flags word and its disable bit
   localparam int unsigned CTX_FLAGS_OFS = 4;
   localparam int unsigned CTX_DIS       = 15;

   // raw event bits
   localparam int unsigned EV_W      = 4;
   localparam int unsigned EV_DONE_A = 0;
   localparam int unsigned EV_DONE_B = 1;
   localparam int unsigned EV_EOP    = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_CAP,
      ST_STREAM,
      ST_WB,
      ST_CTX_REQ,
      ST_CTX_CAP,
      ST_CTX_WR
   } rxdw_state_e;
endpackage

// File: rtl/rxdw_lane_steer.sv
module rxdw_lane_steer #(
   parameter int unsigned LANES = 4,
   localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [7:0]         byte_i,
   input  logic [SEL_W-1:0]   lane_i,
   output logic [LANES-1:0]   be_o,
   output logic [8*LANES-1:0] data_o
);
   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("rxdw_lane_steer: LANES must be a power of two of at least 2");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign be_o[g]          = (lane_i == SEL_W'(g));
         assign data_o[8*g +: 8] = byte_i;
      end
   endgenerate
endmodule

// File: rtl/rxdw_evt.sv
module rxdw_evt
   import rxdw_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            close_i,
   input  logic            irq_i,
   input  logic            eop_i,
   output logic [EV_W-1:0] evt_o
);
   logic [EV_W-1:0] evt_d;

   always_comb begin
      evt_d = '0;
      if (close_i) begin
         evt_d[EV_DONE_A] = irq_i;
         evt_d[EV_DONE_B] = irq_i;
         evt_d[EV_EOP]    = eop_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_o <= '0;
      else        evt_o <= evt_d;
   end
endmodule

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
   import rxdw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] desc_ptr_i,
   input  logic [ADDR_W-1:0] ctx_ptr_i,
   input  logic              s_valid_i,
   input  logic              s_last_i,
   output logic              s_ready_o,
   input  logic [WORD_W-1:0] rdata_i,
   output logic              req_o,
   output logic              we_o,
   output logic              byte_wr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic [LANE_W-1:0] lane_o,
   output logic              close_o,
   output logic              close_irq_o,
   output logic              close_eop_o,
   output logic              running_o,
   output logic              eol_o
);
   rxdw_state_e       st_q;
   logic [ADDR_W-1:0] desc_q, ctx_q, next_q, end_q, ptr_q;
   logic [WORD_W-1:0] flags_q;
   logic [1:0]        idx_q;
   logic              eop_q, eol_q;

   logic [ADDR_W-1:0] ptr_inc, idx_ofs;
   logic              at_end, take, fill_done;

   assign ptr_inc   = ptr_q + ADDR_W'(1);
   assign idx_ofs   = ADDR_W'({idx_q, 2'b00});
   assign at_end    = (ptr_q == end_q);
   assign take      = (st_q == ST_STREAM) && !at_end && s_valid_i;
   assign fill_done = take && ((ptr_inc == end_q) || s_last_i);

   assign s_ready_o   = (st_q == ST_STREAM) && !at_end;
   assign close_o     = (st_q == ST_STREAM) && (at_end || fill_done);
   assign close_eop_o = take && s_last_i;
   assign close_irq_o = flags_q[FL_IRQ];
   assign running_o   = (st_q != ST_IDLE);
   assign eol_o       = eol_q;
   assign lane_o      = ptr_q[LANE_W-1:0];

   always_comb begin
      req_o     = 1'b0;
      we_o      = 1'b0;
      byte_wr_o = 1'b0;
      addr_o    = '0;
      wdata_o   = '0;
      case (st_q)
         ST_RD_REQ: begin
            req_o  = 1'b1;
            addr_o = desc_q + idx_ofs;
         end
         ST_STREAM: begin
            if (take) begin
               req_o     = 1'b1;
               we_o      = 1'b1;
               byte_wr_o = 1'b1;
               addr_o    = {ptr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            end
         end
         ST_WB: begin
            req_o = 1'b1;
            we_o  = 1'b1;
            if (idx_q == 2'd0) begin
               addr_o  = desc_q + ADDR_W'(DW_FLAGS * WORD_BYTES);
               wdata_o = flags_q | ({{(WORD_W-1){1'b0}}, eop_q} << FL_INEOP);
            end else begin
               addr_o  = desc_q + ADDR_W'(DW_END * WORD_BYTES);
               wdata_o = WORD_W'(ptr_q);
            end
         end
         ST_CTX_REQ: begin
            req_o  = 1'b1;
            addr_o = ctx_q + ADDR_W'(CTX_FLAGS_OFS);
         end
         ST_CTX_WR: begin
            req_o   = 1'b1;
            we_o    = 1'b1;
            addr_o  = ctx_q + ADDR_W'(CTX_FLAGS_OFS);
            wdata_o = flags_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         desc_q  <= '0;
         ctx_q   <= '0;
         next_q  <= '0;
         end_q   <= '0;
         ptr_q   <= '0;
         flags_q <= '0;
         idx_q   <= '0;
         eop_q   <= 1'b0;
         eol_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  desc_q <= desc_ptr_i;
                  ctx_q  <= ctx_ptr_i;
                  eol_q  <= 1'b0;
                  idx_q  <= '0;
                  st_q   <= ST_RD_REQ;
               end
            end
            ST_RD_REQ: st_q <= ST_RD_CAP;
            ST_RD_CAP: begin
               case (idx_q)
                  2'(DW_NEXT):  next_q  <= rdata_i[ADDR_W-1:0];
                  2'(DW_BUF):   ptr_q   <= rdata_i[ADDR_W-1:0];
                  2'(DW_FLAGS): flags_q <= rdata_i;
                  default:      end_q   <= rdata_i[ADDR_W-1:0];
               endcase
               if (idx_q == 2'd3) begin
                  idx_q <= '0;
                  eop_q <= 1'b0;
                  st_q  <= ST_STREAM;
               end else begin
                  idx_q <= idx_q + 2'd1;
                  st_q  <= ST_RD_REQ;
               end
            end
            ST_STREAM: begin
               if (take) ptr_q <= ptr_inc;
               if (close_o) begin
                  eop_q <= close_eop_o;
                  idx_q <= '0;
                  st_q  <= ST_WB;
               end
            end
            ST_WB: begin
               if (idx_q == 2'd0) begin
                  idx_q <= 2'd1;
               end else begin
                  idx_q <= '0;
                  if (flags_q[FL_EOL]) begin
                     st_q <= ST_CTX_REQ;
                  end else begin
                     desc_q <= next_q;
                     st_q   <= ST_RD_REQ;
                  end
               end
            end
            ST_CTX_REQ: st_q <= ST_CTX_CAP;
            ST_CTX_CAP: begin
               flags_q <= rdata_i | (WORD_W'(1) << CTX_DIS);
               st_q    <= ST_CTX_WR;
            end
            ST_CTX_WR: begin
               eol_q <= 1'b1;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxdesc_writer.sv
module rxdesc_writer
   import rxdw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [ADDR_W-1:0]     desc_ptr_i,
   input  logic [ADDR_W-1:0]     ctx_ptr_i,
   input  logic                  s_valid_i,
   input  logic [7:0]            s_data_i,
   input  logic                  s_last_i,
   output logic                  s_ready_o,
   output logic                  mem_req_o,
   output logic                  mem_we_o,
   output logic [ADDR_W-1:0]     mem_addr_o,
   output logic [WORD_BYTES-1:0] mem_be_o,
   output logic [WORD_W-1:0]     mem_wdata_o,
   input  logic [WORD_W-1:0]     mem_rdata_i,
   output logic [EV_W-1:0]       evt_o,
   output logic                  running_o,
   output logic                  chan_eol_o
);
   generate
      if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_aw
         $error("rxdesc_writer: ADDR_W must lie between 8 and the word width");
      end
   endgenerate

   logic                  c_req, c_we, c_byte_wr;
   logic [ADDR_W-1:0]     c_addr;
   logic [WORD_W-1:0]     c_wdata;
   logic [LANE_W-1:0]     c_lane;
   logic                  c_close, c_irq, c_eop;
   logic [WORD_BYTES-1:0] st_be;
   logic [WORD_W-1:0]     st_data;

   rxdw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .desc_ptr_i  (desc_ptr_i),
      .ctx_ptr_i   (ctx_ptr_i),
      .s_valid_i   (s_valid_i),
      .s_last_i    (s_last_i),
      .s_ready_o   (s_ready_o),
      .rdata_i     (mem_rdata_i),
      .req_o       (c_req),
      .we_o        (c_we),
      .byte_wr_o   (c_byte_wr),
      .addr_o      (c_addr),
      .wdata_o     (c_wdata),
      .lane_o      (c_lane),
      .close_o     (c_close),
      .close_irq_o (c_irq),
      .close_eop_o (c_eop),
      .running_o   (running_o),
      .eol_o       (chan_eol_o)
   );

   rxdw_lane_steer #(.LANES(WORD_BYTES)) u_steer (
      .byte_i (s_data_i),
      .lane_i (c_lane),
      .be_o   (st_be),
      .data_o (st_data)
   );

   rxdw_evt u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .close_i (c_close),
      .irq_i   (c_irq),
      .eop_i   (c_eop),
      .evt_o   (evt_o)
   );

   assign mem_req_o   = c_req;
   assign mem_we_o    = c_we;
   assign mem_addr_o  = c_addr;
   assign mem_be_o    = c_byte_wr ? st_be : {WORD_BYTES{c_req}};
   assign mem_wdata_o = c_byte_wr ? st_data : c_wdata;
endmodule

// File: rtl/rxdw_chk.sv
module rxdw_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid_i,
   input logic              s_ready_o,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [3:0]        mem_be_o,
   input logic [3:0]        evt_o,
   input logic              running_o,
   input logic              chan_eol_o
);
   // R1: nothing touches memory while idle
   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !running_o |-> !mem_req_o);

   // R2: descriptor and context reads are word aligned
   a_r2_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_we_o) |-> (mem_addr_o[1:0] == 2'b00));

   // R3: an accepted byte is one write with exactly one lane enabled
   a_r3_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid_i && s_ready_o) |-> (mem_req_o && mem_we_o && $countones(mem_be_o) == 1));

   // R6: both done bits pulse together
   a_r6_done_pair: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[0] == evt_o[1]);

   // R8: end of list blocks input and coincides with the stop
   a_r8_eol_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      chan_eol_o |-> !s_ready_o);
   a_r8_eol_stops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_eol_o) |-> !running_o);

   // R9: ready only while running
   a_r9_ready_running: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> running_o);
endmodule

bind rxdesc_writer rxdw_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s_valid_i  (s_valid_i),
   .s_ready_o  (s_ready_o),
   .mem_req_o  (mem_req_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .mem_be_o   (mem_be_o),
   .evt_o      (evt_o),
   .running_o  (running_o),
   .chan_eol_o (chan_eol_o)
);

// File: tb/rxdesc_writer_tb.sv
`timescale 1ns/1ps
module rxdesc_writer_tb;
   localparam int unsigned AW = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] desc_ptr = '0, ctx_ptr = '0;
   logic          s_valid = 1'b0, s_last = 1'b0;
   logic [7:0]    s_data = '0;
   logic          s_ready, mem_req, mem_we, running, chan_eol;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be, evt;
   logic [31:0]   mem_wdata, mem_rdata;

   rxdesc_writer #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .desc_ptr_i(desc_ptr),
      .ctx_ptr_i(ctx_ptr), .s_valid_i(s_valid), .s_data_i(s_data),
      .s_last_i(s_last), .s_ready_o(s_ready), .mem_req_o(mem_req),
      .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .evt_o(evt),
      .running_o(running), .chan_eol_o(chan_eol)
   );

   // memory model: 256 words, read data one cycle after request
   logic [31:0] mem [0:255];
   logic        tb_fill = 1'b0, tb_we = 1'b0;
   logic [7:0]  tb_wa = '0;
   logic [31:0] tb_wd = '0;

   function automatic logic [7:0] pat(input int unsigned a);
      return 8'(a ^ (a >> 3) ^ 32'hA5);
   endfunction

   initial mem_rdata = '0;
   always @(posedge clk) begin
      if (tb_fill) begin
         for (int i = 0; i < 256; i++)
            mem[i] <= {pat(i*4+3), pat(i*4+2), pat(i*4+1), pat(i*4)};
      end else if (tb_we) begin
         mem[tb_wa] <= tb_wd;
      end else if (mem_req && mem_we) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
   end

   int done_cnt = 0, eop_cnt = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (evt[0]) done_cnt++;
         if (evt[3]) eop_cnt++;
      end
   end

   int checks = 0, fails = 0;
   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [7:0] rd_byte(input int unsigned a);
      return mem[a[9:2]][8*a[1:0] +: 8];
   endfunction

   task automatic poke(input int unsigned w, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_wa = 8'(w); tb_wd = d;
   endtask

   // scenario description
   int          n;
   int unsigned len [4], off [4], kk [4], ll [4], irq [4];
   logic [31:0] flg [4];
   logic [31:0] ctxw;
   logic [7:0]  dat [4][16];

   task automatic send(input logic [7:0] d, input bit last);
      int gap = int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         s_valid = 1'b0;
         // R11: stray start pulses while running must be ignored
         if ($urandom % 4 == 0) begin start = 1'b1; desc_ptr = 32'h40; ctx_ptr = 32'h0; end
         else start = 1'b0;
      end
      @(negedge clk);
      start = 1'b0; s_valid = 1'b1; s_data = d; s_last = last;
      while (!s_ready) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic run_chain(input string tag);
      int unsigned exp_done = 0, exp_eop = 0, d0, e0, bufa;
      @(negedge clk); tb_fill = 1'b1;
      @(negedge clk); tb_fill = 1'b0;
      for (int i = 0; i < n; i++) begin
         bufa = 32'h100 + i*32 + off[i];
         poke(i*4 + 0, 32'((i+1)*16));
         poke(i*4 + 1, bufa);
         poke(i*4 + 2, flg[i]);
         poke(i*4 + 3, bufa + len[i]);
         exp_done += irq[i];
         exp_eop  += ll[i];
      end
      poke(33, ctxw);
      @(negedge clk); tb_we = 1'b0;
      d0 = done_cnt; e0 = eop_cnt;
      @(negedge clk); start = 1'b1; desc_ptr = 32'h0; ctx_ptr = 32'h80;
      @(negedge clk); start = 1'b0;
      chk(mem_req && !mem_we && mem_addr == 32'h0, {tag, " R2 first fetch read"}, mem_addr, 32'h0);
      chk(!s_ready, {tag, " R9 ready low during fetch"}, 32'(s_ready), 32'h0);
      for (int i = 0; i < n; i++)
         for (int j = 0; j < int'(kk[i]); j++)
            send(dat[i][j], (j == int'(kk[i]) - 1) && ll[i] != 0);
      @(negedge clk); s_valid = 1'b0; s_last = 1'b0; start = 1'b0;
      while (running) @(negedge clk);
      @(negedge clk);
      chk(chan_eol && !s_ready, {tag, " R8 end of list stops input"}, {30'b0, chan_eol, s_ready}, 32'h2);
      chk(mem[33] == (ctxw | 32'h8000), {tag, " R8 context disable bit"}, mem[33], ctxw | 32'h8000);
      chk(done_cnt - d0 == exp_done, {tag, " R6 done events"}, 32'(done_cnt - d0), exp_done);
      chk(eop_cnt - e0 == exp_eop, {tag, " R5 packet end events"}, 32'(eop_cnt - e0), exp_eop);
      for (int i = 0; i < n; i++) begin
         int bad = 0;
         bufa = 32'h100 + i*32 + off[i];
         chk(mem[i*4+3] == bufa + kk[i], {tag, " R4 R5 R7 R10 R11 end word"}, mem[i*4+3], bufa + kk[i]);
         chk(mem[i*4+2] == (flg[i] | (ll[i] << 14)), {tag, " R5 R10 flags word"}, mem[i*4+2], flg[i] | (ll[i] << 14));
         for (int b = 0; b < 32; b++) begin
            int unsigned a = 32'h100 + i*32 + b;
            if (a >= bufa && a < bufa + kk[i]) begin
               if (rd_byte(a) != dat[i][a - bufa]) bad++;
            end else if (rd_byte(a) != pat(a)) bad++;
         end
         chk(bad == 0, {tag, " R3 buffer bytes and neighbours"}, 32'(bad), 32'h0);
      end
   endtask

   task automatic fill_data();
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 16; j++) dat[i][j] = 8'($urandom);
   endtask

   task automatic random_chain();
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) begin
         len[i] = $urandom % 17;
         off[i] = $urandom % 4;
         kk[i]  = (len[i] == 0) ? 0 : 1 + ($urandom % len[i]);
         ll[i]  = (kk[i] == 0) ? 0 : ((kk[i] < len[i]) ? 1 : ($urandom % 2));
         irq[i] = $urandom % 2;
         flg[i] = (irq[i] << 4) | ((i == n-1) ? 32'h1 : 32'h0) | ($urandom & 32'h00FF_0F00);
      end
      ctxw = $urandom & ~32'h8000;
      fill_data();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog expired, stream never completed actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!s_ready && !running, "R1 idle after reset", {30'b0, s_ready, running}, 32'h0);
      chk(!chan_eol && !mem_req, "R1 no eol, no request", {30'b0, chan_eol, mem_req}, 32'h0);
      chk(evt == 4'h0, "R1 no events", 32'(evt), 32'h0);

      // directed: full buffer, empty buffer (R10), early packet end
      n = 3;
      len = '{4, 0, 6, 0}; off = '{1, 2, 3, 0};
      kk  = '{4, 0, 3, 0}; ll  = '{0, 0, 1, 0}; irq = '{1, 1, 0, 0};
      flg = '{32'h10, 32'h10, 32'h1, 32'h0};
      ctxw = 32'h1234_0077;
      fill_data();
      run_chain("dirA");

      // directed: buffer fills with the packet-end byte (R5 with R4)
      n = 1;
      len = '{7, 0, 0, 0}; off = '{0, 0, 0, 0};
      kk  = '{7, 0, 0, 0}; ll  = '{1, 0, 0, 0}; irq = '{1, 0, 0, 0};
      flg = '{32'h0000_0311, 32'h0, 32'h0, 32'h0};
      ctxw = 32'h0000_7FFF;
      fill_data();
      run_chain("dirB");

      for (int r = 0; r < 6; r++) begin
         random_chain();
         run_chain("rand");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule